// File: doc/BRIEF.md
# Multi-Image Boot Selection Controller

This block decides which of up to four stored boot images is started after a reset, or whether control passes to an alternate image held in the programmable fabric. After a cold reset it walks the images from index 0 upward, asking an external checker for a CRC verdict on each. It launches the first image that passes. A warm reset request keeps the retry history. A software-state word then decides whether the image launched last time is simply started again or whether the search moves on to the next image.

After every image has failed, the controller locks flash booting out. It then tries the fabric fallback, which is taken only when the fabric reports that it is configured and that it offers a fallback image. Later warm resets, such as repeated watchdog resets, go straight back to that fallback check and never probe flash. Only a cold reset, the active-low `rst_n`, clears the last-loaded index, the status word and the lock.

Top module: `boot_image_selector`

## Requirements
- R1: After a cold reset the controller requests CRC checks in ascending index order starting at 0. It launches the first index whose response reports a pass (`crc_rsp_pass`=1). A failing index moves the request on to the next index.
- R2: A launch shows as `launch` high for one cycle, unless a warm request arrives in that cycle. For an image launch, `launch_fallback`=0 and `launch_idx` holds the image index. In the same cycle `last_idx` already equals that index.
- R3: On a warm request (`warm_rst`=1 for one cycle) while not locked, if `sw_state` equals 32'h49535756, the image at `last_idx` is launched in the next cycle without any CRC request.
- R4: On a warm request while not locked and with any other `sw_state`, CRC checks resume at `last_idx`+1 and follow the R1 rules from there. If `last_idx` is already 3, the images count as exhausted.
- R5: When all images are exhausted and both `fab_configured` and `fab_fallback_en` are 1, the controller launches the fallback. It shows `launch`=1, `launch_fallback`=1 and `launch_addr`=32'hC000_0000.
- R6: When all images are exhausted and either fabric flag is 0, the controller halts. It holds `boot_err`=1 with no launch and no CRC request until the next reset or warm request.
- R7: Once the images are exhausted, every later warm request goes straight to the fallback check of R5/R6, whatever the value of `sw_state`, and issues no CRC request.
- R8: `status` bit 0 marks exhaustion. Bit 1 marks that a flash image was launched. Bits 11:8 hold the `flash_src` value sampled at the last image launch (0 NAND, 1 SD/MMC, 2 QSPI). All other bits read 0.
- R9: A cold reset clears `last_idx`, `status` and the exhaustion lock to 0. A warm request leaves all three unchanged.
- R10: `crc_req_valid` with a stable `crc_req_idx` is held until `crc_req_ready` is seen. After that the controller waits for `crc_rsp_valid` for as long as it takes, with no time limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous active low, released synchronously |
| warm_rst | input | 1 | One-cycle warm reset request |
| sw_state | input | 32 | Software-state word left by the previous boot stage |
| flash_src | input | 2 | Flash source code recorded in status on image launch |
| crc_req_valid | output | 1 | CRC check request |
| crc_req_ready | input | 1 | Checker accepts the request |
| crc_req_idx | output | 2 | Image index to check |
| crc_rsp_valid | input | 1 | CRC verdict present |
| crc_rsp_pass | input | 1 | CRC verdict, 1 = image good |
| fab_configured | input | 1 | Fabric configured and running |
| fab_fallback_en | input | 1 | Fabric offers a fallback image |
| launch | output | 1 | One-cycle launch strobe |
| launch_fallback | output | 1 | Launch targets the fabric fallback |
| launch_idx | output | 2 | Index of the launched image |
| launch_addr | output | 32 | Fallback target address, 0 when not a fallback |
| last_idx | output | 2 | Last-loaded image index |
| status | output | 32 | Boot status word |
| boot_err | output | 1 | Terminal halt, no bootable image |

## Verification
The hardest state to reach is the exhaustion lock being exercised by later warm requests, because it requires a history. The stimulus first builds that history: a cold boot onto image 2, a matching-word warm relaunch, a mismatching warm request that advances to image 3, and a second mismatch that exhausts the images and halts. Only after that are warm requests issued with the magic word present and the fabric flags raised. The bench then confirms a fallback launch with no CRC request and a preserved status, and a final cold reset must clear everything.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  localparam logic [31:0] SW_OK_WORD    = 32'h4953_5756;
  localparam logic [31:0] FALLBACK_ADDR = 32'hC000_0000;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_REQ,
    ST_WAIT,
    ST_EXHAUST,
    ST_DONE,
    ST_HALT
  } sel_state_e;

endpackage

// File: rtl/boot_sel_fsm.sv
module boot_sel_fsm
  import boot_sel_pkg::*;
#(
  parameter int NUM_IMG = 4,
  parameter int IDX_W   = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic [31:0]      sw_state,
  input  logic             crc_req_ready,
  input  logic             crc_rsp_valid,
  input  logic             crc_rsp_pass,
  input  logic             fab_configured,
  input  logic             fab_fallback_en,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             locked,
  output logic             crc_req_valid,
  output logic [IDX_W-1:0] crc_req_idx,
  output logic             launch,
  output logic             launch_fallback,
  output logic [IDX_W-1:0] launch_idx,
  output logic             boot_err,
  output logic             upd_img,
  output logic [IDX_W-1:0] upd_idx,
  output logic             upd_exh
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IMG - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  sel_state_e       state_q, state_n;
  logic [IDX_W-1:0] cur_q, cur_n;
  logic             fire_img, fire_fb;
  logic [IDX_W-1:0] img_n;
  logic             launch_q, launch_fb_q;
  logic [IDX_W-1:0] launch_idx_q;

  always_comb begin
    state_n  = state_q;
    cur_n    = cur_q;
    fire_img = 1'b0;
    fire_fb  = 1'b0;
    img_n    = cur_q;
    upd_exh  = 1'b0;
    if (warm_rst) begin
      if (locked) begin
        state_n = ST_EXHAUST;
      end else if (sw_state == SW_OK_WORD) begin
        fire_img = 1'b1;
        img_n    = last_idx;
        state_n  = ST_DONE;
      end else if (last_idx == LAST_IDX) begin
        state_n = ST_EXHAUST;
      end else begin
        cur_n   = last_idx + ONE_IDX;
        state_n = ST_REQ;
      end
    end else begin
      case (state_q)
        ST_BOOT: begin
          cur_n   = '0;
          state_n = ST_REQ;
        end
        ST_REQ: begin
          if (crc_req_ready) state_n = ST_WAIT;
        end
        ST_WAIT: begin
          if (crc_rsp_valid) begin
            if (crc_rsp_pass) begin
              fire_img = 1'b1;
              state_n  = ST_DONE;
            end else if (cur_q == LAST_IDX) begin
              state_n = ST_EXHAUST;
            end else begin
              cur_n   = cur_q + ONE_IDX;
              state_n = ST_REQ;
            end
          end
        end
        ST_EXHAUST: begin
          upd_exh = 1'b1;
          if (fab_configured && fab_fallback_en) begin
            fire_fb = 1'b1;
            state_n = ST_DONE;
          end else begin
            state_n = ST_HALT;
          end
        end
        default: state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_BOOT;
      cur_q        <= '0;
      launch_q     <= 1'b0;
      launch_fb_q  <= 1'b0;
      launch_idx_q <= '0;
    end else begin
      state_q     <= state_n;
      cur_q       <= cur_n;
      launch_q    <= fire_img | fire_fb;
      launch_fb_q <= fire_fb;
      if (fire_img) launch_idx_q <= img_n;
    end
  end

  assign crc_req_valid   = (state_q == ST_REQ);
  assign crc_req_idx     = cur_q;
  assign boot_err        = (state_q == ST_HALT);
  assign launch          = launch_q;
  assign launch_fallback = launch_fb_q;
  assign launch_idx      = launch_idx_q;
  assign upd_img         = fire_img;
  assign upd_idx         = img_n;

endmodule

// File: rtl/boot_sel_state.sv
module boot_sel_state #(
  parameter int IDX_W = 2,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_img,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_exh,
  input  logic [SRC_W-1:0] flash_src,
  output logic [IDX_W-1:0] last_idx,
  output logic             locked,
  output logic [31:0]      status
);

  localparam int FIELD_W = 4;

  logic [IDX_W-1:0]   last_q;
  logic               exh_q;
  logic               started_q;
  logic [FIELD_W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= '0;
      exh_q     <= 1'b0;
      started_q <= 1'b0;
      src_q     <= '0;
    end else begin
      if (upd_img) begin
        last_q    <= upd_idx;
        started_q <= 1'b1;
        src_q     <= FIELD_W'(flash_src);
      end
      if (upd_exh) exh_q <= 1'b1;
    end
  end

  assign last_idx = last_q;
  assign locked   = exh_q;
  assign status   = {20'd0, src_q, 6'd0, started_q, exh_q};

endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
  import boot_sel_pkg::*;
#(
  parameter int NUM_IMG = 4,
  parameter int SRC_W   = 2,
  parameter int IDX_W   = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic [31:0]      sw_state,
  input  logic [SRC_W-1:0] flash_src,
  output logic             crc_req_valid,
  input  logic             crc_req_ready,
  output logic [IDX_W-1:0] crc_req_idx,
  input  logic             crc_rsp_valid,
  input  logic             crc_rsp_pass,
  input  logic             fab_configured,
  input  logic             fab_fallback_en,
  output logic             launch,
  output logic             launch_fallback,
  output logic [IDX_W-1:0] launch_idx,
  output logic [31:0]      launch_addr,
  output logic [IDX_W-1:0] last_idx,
  output logic [31:0]      status,
  output logic             boot_err
);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             locked;
  logic             upd_img, upd_exh;
  logic [IDX_W-1:0] upd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  boot_sel_fsm #(.NUM_IMG(NUM_IMG), .IDX_W(IDX_W)) u_fsm (
    .clk             (clk),
    .rst_n           (core_rst_n),
    .warm_rst        (warm_rst),
    .sw_state        (sw_state),
    .crc_req_ready   (crc_req_ready),
    .crc_rsp_valid   (crc_rsp_valid),
    .crc_rsp_pass    (crc_rsp_pass),
    .fab_configured  (fab_configured),
    .fab_fallback_en (fab_fallback_en),
    .last_idx        (last_idx),
    .locked          (locked),
    .crc_req_valid   (crc_req_valid),
    .crc_req_idx     (crc_req_idx),
    .launch          (launch),
    .launch_fallback (launch_fallback),
    .launch_idx      (launch_idx),
    .boot_err        (boot_err),
    .upd_img         (upd_img),
    .upd_idx         (upd_idx),
    .upd_exh         (upd_exh)
  );

  boot_sel_state #(.IDX_W(IDX_W), .SRC_W(SRC_W)) u_state (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .upd_img   (upd_img),
    .upd_idx   (upd_idx),
    .upd_exh   (upd_exh),
    .flash_src (flash_src),
    .last_idx  (last_idx),
    .locked    (locked),
    .status    (status)
  );

  assign launch_addr = launch_fallback ? FALLBACK_ADDR : 32'd0;

endmodule

// File: rtl/boot_image_selector_chk.sv
module boot_image_selector_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warm_rst,
  input logic             crc_req_valid,
  input logic             crc_req_ready,
  input logic [IDX_W-1:0] crc_req_idx,
  input logic             launch,
  input logic             launch_fallback,
  input logic [IDX_W-1:0] launch_idx,
  input logic [31:0]      launch_addr,
  input logic [IDX_W-1:0] last_idx,
  input logic [31:0]      status,
  input logic             boot_err
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    crc_req_valid && !crc_req_ready && !warm_rst |=> crc_req_valid && $stable(crc_req_idx)); // R10

  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !warm_rst |=> !launch); // R2

  AST_LAUNCH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !launch_fallback |-> last_idx == launch_idx && status[1]); // R2

  AST_FALLBACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    launch && launch_fallback |-> launch_addr == 32'hC000_0000 && status[0]); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |-> !crc_req_valid && !launch); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> status[0]); // R7

  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~32'h0000_0F03) == 32'd0); // R8

endmodule

bind boot_image_selector boot_image_selector_chk #(.IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .warm_rst        (warm_rst),
  .crc_req_valid   (crc_req_valid),
  .crc_req_ready   (crc_req_ready),
  .crc_req_idx     (crc_req_idx),
  .launch          (launch),
  .launch_fallback (launch_fallback),
  .launch_idx      (launch_idx),
  .launch_addr     (launch_addr),
  .last_idx        (last_idx),
  .status          (status),
  .boot_err        (boot_err)
);

// File: tb/boot_image_selector_test.sv
module boot_image_selector_test;

  localparam logic [31:0] MAGIC = 32'h4953_5756;

  logic        clk = 1'b0;
  logic        rst_n, warm_rst;
  logic [31:0] sw_state;
  logic [1:0]  flash_src;
  logic        crc_req_valid, crc_req_ready;
  logic [1:0]  crc_req_idx;
  logic        crc_rsp_valid, crc_rsp_pass;
  logic        fab_configured, fab_fallback_en;
  logic        launch, launch_fallback;
  logic [1:0]  launch_idx, last_idx;
  logic [31:0] launch_addr, status;
  logic        boot_err;

  always #2 clk = ~clk;

  boot_image_selector uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .sw_state(sw_state),
    .flash_src(flash_src), .crc_req_valid(crc_req_valid), .crc_req_ready(crc_req_ready),
    .crc_req_idx(crc_req_idx), .crc_rsp_valid(crc_rsp_valid), .crc_rsp_pass(crc_rsp_pass),
    .fab_configured(fab_configured), .fab_fallback_en(fab_fallback_en),
    .launch(launch), .launch_fallback(launch_fallback), .launch_idx(launch_idx),
    .launch_addr(launch_addr), .last_idx(last_idx), .status(status), .boot_err(boot_err)
  );

  int total = 0, failed = 0;
  bit finished = 0;

  logic       r_launch, r_fb, r_err;
  logic [1:0] r_idx;
  int         r_tries, r_first;
  logic [31:0] r_addr;

  // {mask[3:0], cfg, fb_en, kind[1:0] (0 img,1 fallback,2 halt), idx[1:0], tries[2:0], pad[2:0]}
  localparam logic [15:0] VEC [7] = '{
    {4'b1111, 1'b0, 1'b0, 2'd0, 2'd0, 3'd1, 3'd0},
    {4'b0100, 1'b0, 1'b0, 2'd0, 2'd2, 3'd3, 3'd0},
    {4'b1000, 1'b0, 1'b0, 2'd0, 2'd3, 3'd4, 3'd0},
    {4'b0000, 1'b1, 1'b1, 2'd1, 2'd0, 3'd4, 3'd0},
    {4'b0000, 1'b1, 1'b0, 2'd2, 2'd0, 3'd4, 3'd0},
    {4'b0000, 1'b0, 1'b1, 2'd2, 2'd0, 3'd4, 3'd0},
    {4'b0110, 1'b1, 1'b1, 2'd0, 2'd1, 3'd2, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // CRC responder; mask bit i = verdict for image i. Ends on launch or halt.
  task automatic run_boot(input logic [3:0] mask);
    bit pending = 0;
    logic [1:0] pidx = 0;
    r_launch = 0; r_fb = 0; r_err = 0; r_idx = 0; r_tries = 0; r_first = -1; r_addr = 0;
    crc_rsp_valid = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      warm_rst = 0;
      if (crc_rsp_valid) crc_rsp_valid = 0;
      if (launch) begin
        r_launch = 1; r_fb = launch_fallback; r_idx = launch_idx; r_addr = launch_addr;
        break;
      end
      if (boot_err) begin
        r_err = 1;
        break;
      end
      if (pending) begin
        crc_rsp_valid = 1; crc_rsp_pass = mask[pidx]; pending = 0;
      end else if (crc_req_valid) begin
        pidx = crc_req_idx; pending = 1;
        if (r_tries == 0) r_first = int'(crc_req_idx);
        r_tries++;
      end
    end
  endtask

  task automatic cold_reset();
    @(negedge clk);
    rst_n = 0; warm_rst = 0; crc_rsp_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic warm_request(input logic [31:0] word);
    @(negedge clk);
    sw_state = word; warm_rst = 1;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; warm_rst = 0; sw_state = 0; flash_src = 0; crc_req_ready = 1;
    crc_rsp_valid = 0; crc_rsp_pass = 0; fab_configured = 0; fab_fallback_en = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset status", status, 0);
    chk("R9 reset last_idx", 32'(last_idx), 0);
    chk("R6 reset boot_err", 32'(boot_err), 0);
    chk("R10 reset req", 32'(crc_req_valid), 0);
    chk("R2 reset launch", 32'(launch), 0);

    // vector table of cold boots
    for (int v = 0; v < 7; v++) begin
      logic [15:0] e;
      logic [31:0] exp_st;
      e = VEC[v];
      flash_src = 2'(v % 3);
      fab_configured = e[11]; fab_fallback_en = e[10];
      cold_reset();
      run_boot(e[15:12]);
      chk("R1 first index", 32'(r_first), 0);
      chk("R1 tries", 32'(r_tries), 32'(e[5:3]));
      if (e[9:8] == 2'd0) begin
        exp_st = (32'(v % 3) << 8) | 32'h2;
        chk("R1 image launched", {r_launch, r_fb, r_err}, 3'b100);
        chk("R2 launch_idx", 32'(r_idx), 32'(e[7:6]));
        chk("R2 last_idx", 32'(last_idx), 32'(e[7:6]));
        chk("R8 status image", status, exp_st);
      end else if (e[9:8] == 2'd1) begin
        chk("R5 fallback launched", {r_launch, r_fb, r_err}, 3'b110);
        chk("R5 fallback addr", r_addr, 32'hC000_0000);
        chk("R8 status exhausted", status, 32'h1);
      end else begin
        chk("R6 halt", {r_launch, r_err}, 2'b01);
        repeat (5) @(negedge clk);
        chk("R6 halt held", {launch, crc_req_valid, boot_err}, 3'b001);
        chk("R8 status halt", status, 32'h1);
      end
    end

    // R10: request held while not ready, then indefinite wait for verdict
    cold_reset();
    crc_req_ready = 0;
    repeat (20) @(negedge clk);
    chk("R10 req held", {crc_req_valid, crc_req_idx, launch}, 4'b1000);
    crc_req_ready = 1;
    repeat (30) @(negedge clk);
    chk("R10 waiting", {crc_req_valid, launch}, 2'b00);
    crc_rsp_valid = 1; crc_rsp_pass = 1;
    @(negedge clk);
    crc_rsp_valid = 0;
    chk("R10 late verdict launch", {launch, launch_fallback, launch_idx}, 4'b1000);

    // history: cold boot to image 2 on SD/MMC
    fab_configured = 0; fab_fallback_en = 0; flash_src = 2'd1;
    cold_reset();
    run_boot(4'b0100);
    chk("R1 boot image 2", 32'(r_idx), 2);
    // R3: magic match relaunch, no CRC
    flash_src = 2'd2;
    warm_request(MAGIC);
    run_boot(4'b0000);
    chk("R3 relaunch", {r_launch, r_fb, r_idx}, 4'b1010);
    chk("R3 no crc", 32'(r_tries), 0);
    chk("R9 warm keeps last_idx", 32'(last_idx), 2);
    chk("R8 src sampled on relaunch", status, 32'h202);
    // R4: mismatch advances to index 3
    flash_src = 2'd0;
    warm_request(32'h0);
    run_boot(4'b1111);
    chk("R4 first after advance", 32'(r_first), 3);
    chk("R4 launch idx3", {r_launch, r_idx}, 3'b111);
    chk("R4 last_idx", 32'(last_idx), 3);
    chk("R8 status NAND", status, 32'h002);
    // R4/R6: mismatch at index 3 exhausts and halts
    warm_request(32'h1234_5678);
    run_boot(4'b1111);
    chk("R6 halt after exhaust", {r_launch, r_err}, 2'b01);
    chk("R4 no crc at exhaust", 32'(r_tries), 0);
    chk("R9 warm keeps status", status, 32'h003);
    // R7: locked, magic word ignored, fallback now available
    fab_configured = 1; fab_fallback_en = 1;
    warm_request(MAGIC);
    run_boot(4'b1111);
    chk("R7 locked fallback", {r_launch, r_fb}, 2'b11);
    chk("R7 no crc when locked", 32'(r_tries), 0);
    chk("R5 fallback addr locked", r_addr, 32'hC000_0000);
    chk("R9 warm keeps last_idx 3", 32'(last_idx), 3);
    // R9: cold reset clears everything
    cold_reset();
    chk("R9 cold clears status", status, 0);
    chk("R9 cold clears last_idx", 32'(last_idx), 0);
    run_boot(4'b1111);
    chk("R9 flash resumes after cold", {r_launch, r_fb, r_idx}, 4'b1000);
    chk("R9 one try after cold", 32'(r_tries), 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule